// File: doc/BRIEF.md
# Prescaled PWM Timer

This block generates a pulse-width-modulated output from an 8-bit timer. A prescaler divides the input clock by 4, 16 or 64, which is four clocks per step times a selectable 1, 4 or 16. Each divided step advances an up-counter. When the counter matches the period register, it returns to zero. That match is called a rollover. At each rollover the output goes high, provided the duty value now in force is nonzero. The output goes low at the counter step that reaches the duty value.

Software writes the period, duty and prescale settings through plain write strobes that share one data bus. The duty setting goes into a shadow register and is copied into the active compare register only at a rollover. This means the next pulse width can be queued a whole period in advance. The period register has no shadow, so a new period applies to the period already running. A sticky interrupt flag records every rollover and stays set until software clears it. Software can count these flags to build frames longer than 256 counter steps, or pulses wider than one period, by holding the duty above the period.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset, `pwm_out` and `irq_flag` are low. The period is 255, the prescale code is 00 and both the shadow and active duty are 0.
- R2: The prescale code is taken from `wr_data[1:0]` when `wr_presc` is high. Code 00 gives one counter step every 4 clocks, code 01 every 16 clocks, and codes 10 and 11 every 64 clocks.
- R3: With period value P and S clocks per step, rollovers are spaced (P+1)·S clocks apart, and the counter restarts from 0 at each one.
- R4: With an active duty D where 0 < D ≤ P, `pwm_out` rises at the rollover and stays high for exactly D·S clocks.
- R5: A duty write lands in the shadow register only. The pulse in progress keeps its old width, and the written value governs the pulse that starts at the next rollover.
- R6: When the active duty is 0, `pwm_out` stays low for the whole period, yet `irq_flag` still sets at the rollover.
- R7: When the active duty exceeds the period value, `pwm_out` stays high continuously, across rollovers.
- R8: A period write applies at once to the running count. The rollover that ends the current period already uses the new value.
- R9: `irq_flag` sets at every rollover and stays set until `irq_clr` is pulsed. If a rollover and a clear happen in the same cycle, the flag is set.
- R10: The prescaler restarts from zero at every rollover, so every period begins on a whole step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_period | input | 1 | Write strobe for the period register |
| wr_duty | input | 1 | Write strobe for the duty shadow register |
| wr_presc | input | 1 | Write strobe for the prescale code (`wr_data[1:0]`) |
| wr_data | input | 8 | Shared write data |
| irq_clr | input | 1 | Clears the rollover flag |
| pwm_out | output | 1 | PWM output |
| irq_flag | output | 1 | Sticky rollover flag |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running period. The bench must show that a duty write leaves the pulse in progress untouched, while a period write shortens the period in progress. To do this, the bench first clears the flag and waits for it to set, which places it one clock after a known rollover. On that same sample it drives the write. It then times the remainder of that period, and the following one, clock by clock, and compares the measured high time and period length against values computed from the step size.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Prescale code as written on the data bus
  typedef enum logic [1:0] {
    PSEL_X1  = 2'b00,
    PSEL_X4  = 2'b01,
    PSEL_X16 = 2'b10,
    PSEL_X16B = 2'b11
  } psel_e;

  localparam int unsigned CNT_W  = 8;   // counter, period and duty width
  localparam int unsigned STEP   = 4;   // input clocks per undivided step
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int unsigned CLK_PER_STEP = STEP
) (
  input  logic  clk,
  input  logic  rst_n,
  input  psel_e sel,
  input  logic  restart,
  output logic  tick
);
  localparam int unsigned PRE_W = $clog2(CLK_PER_STEP * 16);
  localparam logic [PRE_W-1:0] LIM_X1  = PRE_W'(CLK_PER_STEP - 1);
  localparam logic [PRE_W-1:0] LIM_X4  = PRE_W'(CLK_PER_STEP * 4 - 1);
  localparam logic [PRE_W-1:0] LIM_X16 = PRE_W'(CLK_PER_STEP * 16 - 1);

  logic [PRE_W-1:0] pcnt_q, pcnt_d, lim;

  always_comb begin
    case (sel)
      PSEL_X1: lim = LIM_X1;
      PSEL_X4: lim = LIM_X4;
      default: lim = LIM_X16;
    endcase
  end

  // ">=" keeps the count bounded when the code shrinks mid-step
  assign tick = (pcnt_q >= lim);

  always_comb begin
    if (tick || restart) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (LIM_X1 != '0)) |=> !tick); // R2
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (LIM_X1 != '0)) |=> !tick); // R10
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt_next,
  output logic         rollover
);
  logic [W-1:0] cnt_q;

  assign rollover = tick && (cnt_q == period);

  always_comb begin
    if (rollover)  cnt_next = '0;
    else if (tick) cnt_next = cnt_q + 1'b1;
    else           cnt_next = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (cnt_q == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rollover) |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         tick,
  input  logic         rollover,
  input  logic [W-1:0] cnt_next,
  output logic [W-1:0] active,
  output logic         pwm
);
  logic [W-1:0] shadow_q, shadow_d, active_q, active_d;
  logic         pwm_q, pwm_d;

  always_comb begin
    shadow_d = wr_en ? wr_val : shadow_q;
    active_d = rollover ? shadow_q : active_q;
    if (rollover)
      pwm_d = (shadow_q != '0);
    else if (tick && (cnt_next == active_q))
      pwm_d = 1'b0;
    else
      pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
      pwm_q    <= pwm_d;
    end
  end

  assign active = active_q;
  assign pwm    = pwm_q;

  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (active_q == $past(shadow_q))); // R5
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rollover |=> $stable(active_q)); // R5
  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && (shadow_q == '0)) |=> !pwm_q); // R6
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && (shadow_q != '0)) |=> pwm_q); // R4
endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_period,
  input  logic       wr_duty,
  input  logic       wr_presc,
  input  logic [7:0] wr_data,
  input  logic       irq_clr,
  output logic       pwm_out,
  output logic       irq_flag
);
  localparam int unsigned W = CNT_W;

  logic         rst_meta_q, rst_int_n;
  logic [W-1:0] period_q, period_d;
  psel_e        psel_q, psel_d;
  logic         flag_q, flag_d;
  logic         tick, rollover;
  logic [W-1:0] cnt_next, active;

  // Reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  always_comb begin
    period_d = wr_period ? wr_data[W-1:0] : period_q;
    psel_d   = wr_presc ? psel_e'(wr_data[1:0]) : psel_q;
    if (rollover)     flag_d = 1'b1;
    else if (irq_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      period_q <= '1;
      psel_q   <= PSEL_X1;
      flag_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      psel_q   <= psel_d;
      flag_q   <= flag_d;
    end
  end

  pwm_prescaler #(.CLK_PER_STEP(STEP)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel     (psel_q),
    .restart (rollover),
    .tick    (tick)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .period   (period_q),
    .cnt_next (cnt_next),
    .rollover (rollover)
  );

  pwm_duty #(.W(W)) u_duty (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_duty),
    .wr_val   (wr_data[W-1:0]),
    .tick     (tick),
    .rollover (rollover),
    .cnt_next (cnt_next),
    .active   (active),
    .pwm      (pwm_out)
  );

  assign irq_flag = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    rollover |=> flag_q); // R9
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_clr && !rollover) |=> !flag_q); // R9
  AST_OVER_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rollover && pwm_out && (active > period_q) && !wr_period && !wr_duty)
      |=> pwm_out); // R7
endmodule

// File: tb/pwm_timer_top_tb.sv
module pwm_timer_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_period, wr_duty, wr_presc, irq_clr;
  logic [7:0] wr_data;
  logic       pwm_out, irq_flag;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwm_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_period(wr_period), .wr_duty(wr_duty),
    .wr_presc(wr_presc), .wr_data(wr_data), .irq_clr(irq_clr),
    .pwm_out(pwm_out), .irq_flag(irq_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // kind: 1 period, 2 duty, 3 prescale
  task automatic write_reg(input int kind, input logic [7:0] val);
    wr_data   = val;
    wr_period = (kind == 1);
    wr_duty   = (kind == 2);
    wr_presc  = (kind == 3);
    @(negedge clk);
    wr_period = 1'b0; wr_duty = 1'b0; wr_presc = 1'b0;
  endtask

  // Returns on the first sample after a rollover
  task automatic sync_roll();
    int n = 0;
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    while (!irq_flag && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 40000) check("sync timeout", n, 0);
  endtask

  // From a sample just after a rollover: high samples and rise-to-rise length.
  // Optionally writes a register on the first sample.
  task automatic measure(input int wkind, input logic [7:0] wval,
                         output int hi, output int per);
    int  j = 0;
    bit  seen_low = 0;
    hi = 0; per = -1;
    if (wkind != 0) begin
      wr_data   = wval;
      wr_period = (wkind == 1);
      wr_duty   = (wkind == 2);
    end
    forever begin
      if (pwm_out && seen_low) begin per = j; break; end
      if (pwm_out) hi++; else seen_low = 1;
      @(negedge clk);
      wr_period = 1'b0; wr_duty = 1'b0;
      j++;
      if (j > 40000) break;
    end
  endtask

  task automatic t_reset();
    check("R1 pwm_out after reset", pwm_out, 0);
    check("R1 irq_flag after reset", irq_flag, 0);
  endtask

  task automatic t_defaults();
    int hi, per;
    write_reg(2, 8'd1);
    sync_roll();
    measure(0, 8'd0, hi, per);
    check("R1 default period 255, code 00: length", per, 1024);
    check("R4 duty 1 high time", hi, 4);
  endtask

  task automatic t_div(input logic [1:0] code, input logic [7:0] p,
                       input logic [7:0] d, input int s);
    int hi, per;
    write_reg(3, {6'd0, code});
    write_reg(1, p);
    write_reg(2, d);
    sync_roll();
    measure(0, 8'd0, hi, per);
    check($sformatf("R2 R3 code %0d period length", code), per, (p + 1) * s);
    check($sformatf("R4 code %0d high time", code), hi, d * s);
    measure(0, 8'd0, hi, per);
    check("R10 second period same length", per, (p + 1) * s);
  endtask

  task automatic t_buffer();
    int hi, per;
    write_reg(3, 8'd0); write_reg(1, 8'd9); write_reg(2, 8'd4);
    sync_roll();
    measure(2, 8'd7, hi, per);
    check("R5 pulse in progress keeps old width", hi, 16);
    check("R5 period length unchanged", per, 40);
    measure(0, 8'd0, hi, per);
    check("R5 next pulse uses new width", hi, 28);
  endtask

  task automatic t_zero();
    int highs = 0;
    write_reg(1, 8'd9); write_reg(2, 8'd0);
    sync_roll();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    for (int i = 0; i < 85; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
    check("R6 zero duty keeps output low", highs, 0);
    check("R6 flag still set by rollover", irq_flag, 1);
  endtask

  task automatic t_over();
    int lows = 0;
    write_reg(1, 8'd5); write_reg(2, 8'd9);
    sync_roll();
    for (int i = 0; i < 80; i++) begin
      if (!pwm_out) lows++;
      @(negedge clk);
    end
    check("R7 duty above period holds output high", lows, 0);
  endtask

  task automatic t_period_live();
    int hi, per;
    write_reg(1, 8'd9); write_reg(2, 8'd1);
    sync_roll();
    sync_roll();
    measure(1, 8'd3, hi, per);
    check("R8 period write shortens running period", per, 16);
    check("R8 high time unaffected", hi, 4);
  endtask

  task automatic t_flag();
    sync_roll();
    check("R9 flag set after rollover", irq_flag, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check("R9 flag cleared by irq_clr", irq_flag, 0);
    repeat (5) @(negedge clk);
    check("R9 flag stays clear before next rollover", irq_flag, 0);
    repeat (12) @(negedge clk);
    check("R9 flag set again at next rollover", irq_flag, 1);
    repeat (30) @(negedge clk);
    check("R9 flag stays set without clear", irq_flag, 1);
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_period = 1'b0; wr_duty = 1'b0; wr_presc = 1'b0;
    irq_clr = 1'b0; wr_data = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_defaults();
    t_div(2'b00, 8'd9, 8'd4, 4);
    t_div(2'b01, 8'd9, 8'd4, 16);
    t_div(2'b10, 8'd3, 8'd1, 64);
    t_div(2'b11, 8'd3, 8'd2, 64);
    t_buffer();
    t_zero();
    t_over();
    t_period_live();
    t_flag();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule